// File: doc/BRIEF.md
# Host DMA Mailbox Handshake

This block moves single bytes between a PC-style host DMA controller and a local microprocessor. It holds two one-byte mailboxes, one for each direction. Firmware fills the outgoing mailbox or empties the incoming one through a small register window. When a direction is ready, firmware asks for a host DMA transfer. The block then raises an active-high request to the host. The host's DMA controller answers with an active-low acknowledge and then a read or write strobe.

Every host control line passes through a synchroniser before the local logic uses it. Host data passes through a delay line of matching depth. A request is withdrawn only when the strobe's falling edge is seen inside the acknowledge. The acknowledge arriving on its own does not withdraw it. A transfer is committed when that strobe returns high. Two outputs are decoded straight from the host pins so that they act in time for the host bus: the host data driver disable and the ordinary chip-select. A DMA cycle never produces the chip-select.

Top module: `host_dma_mailbox`

## Requirements
- R1: After a synchronous reset the request output is low, the driver disable and chip-select outputs are high, and the local status register reads 0.
- R2: Writing the control register (local address 2) with bit 0 set arms a host-write request and raises `host_req`. This happens only while the incoming mailbox is empty; when that mailbox is full the write has no effect.
- R3: Writing the control register with bit 1 set arms a host-read request. This happens only while the outgoing mailbox is full; when it is empty the write has no effect.
- R4: An armed host-write request keeps `host_req` high while the acknowledge alone is active. It drops it only after the write strobe's falling edge is seen while the acknowledge is active.
- R5: An armed host-read request keeps `host_req` high while the acknowledge alone is active. It drops it only after the read strobe's falling edge is seen while the acknowledge is active.
- R6: When the write strobe rises after that falling edge, the host byte is captured and the incoming-full flag (status bit 0) sets. A local read of the data register (address 0) returns the byte and clears the flag.
- R7: A local write to the data register while the outgoing mailbox is empty loads the byte and sets the outgoing-full flag (status bit 1). While that flag is set, further local data writes are ignored and `host_data_out` keeps its value.
- R8: During a host DMA read `host_data_out` carries the outgoing byte. When the read strobe rises, the outgoing-full flag clears.
- R9: `host_drv_dis_n` is low while the read strobe is low and either the acknowledge is active or `host_port_sel` is high. It is high during a DMA write.
- R10: `host_cs_n` is low only for an ordinary strobe with `host_port_sel` high and the acknowledge inactive. It is never low during a DMA acknowledge.
- R11: Host strobes that arrive while no request of that direction is armed change neither flag nor the request output.
- Status bit 2 shows that the host-write request is armed, and status bit 3 shows that the host-read request is armed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock |
| rst | input | 1 | Synchronous reset, active high |
| host_ack_n | input | 1 | Host DMA acknowledge, active low |
| host_wr_n | input | 1 | Host write strobe, active low |
| host_rd_n | input | 1 | Host read strobe, active low |
| host_port_sel | input | 1 | Ordinary interface address match from the host decode |
| host_data_in | input | DATA_W | Host write data |
| host_data_out | output | DATA_W | Byte offered to host reads |
| host_req | output | 1 | DMA request to host, active high |
| host_drv_dis_n | output | 1 | Host data driver disable, active low |
| host_cs_n | output | 1 | Chip-select for ordinary accesses, active low |
| loc_wr | input | 1 | Local register write strobe |
| loc_rd | input | 1 | Local register read strobe |
| loc_addr | input | ADDR_W | Local register address: 0 data, 1 status, 2 control |
| loc_wdata | input | DATA_W | Local write data |
| loc_rdata | output | DATA_W | Registered local read data |

## Verification
The bench holds the acknowledge active for several cycles before any strobe. A design that drops the request when the acknowledge arrives therefore shows it at once. It then checks that the request falls on the strobe edge and not earlier. It sends stray strobes, with and without an acknowledge, while nothing is armed. A design that accepts them would set a full flag. It tries to arm each direction in the wrong mailbox state, and to overwrite a full outgoing byte, so that a missing guard shows up as a raised request or changed data. It drives ordinary reads and DMA cycles separately, so that a chip-select that leaks into DMA cycles, or a driver disable that ignores one of its two causes, is reported.

// File: rtl/hdm_pkg.sv
package hdm_pkg;
  typedef enum logic [1:0] {
    XS_IDLE   = 2'd0,
    XS_ARMED  = 2'd1,
    XS_MOVING = 2'd2
  } xfer_st_e;

  localparam logic [1:0] RA_DATA = 2'd0;
  localparam logic [1:0] RA_STAT = 2'd1;
  localparam logic [1:0] RA_CTRL = 2'd2;

  localparam int ST_H2L_FULL = 0;
  localparam int ST_L2H_FULL = 1;
  localparam int ST_W_ARMED  = 2;
  localparam int ST_R_ARMED  = 3;

  localparam int CTL_ARM_W = 0;
  localparam int CTL_ARM_R = 1;
endpackage

// File: rtl/hdm_sync.sv
module hdm_sync #(
  parameter int              W       = 1,
  parameter int              STAGES  = 2,
  parameter logic [W-1:0]    RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) chain[g] <= RST_VAL;
        else     chain[g] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) chain[g] <= RST_VAL;
        else     chain[g] <= chain[g-1];
      end
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/hdm_dir.sv
module hdm_dir
  import hdm_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic arm,
  input  logic in_cycle,
  input  logic strb_fall,
  input  logic strb_rise,
  output logic armed,
  output logic moving,
  output logic commit
);
  xfer_st_e st;

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= XS_IDLE;
    end else begin
      case (st)
        XS_IDLE:   if (arm) st <= XS_ARMED;
        XS_ARMED:  if (strb_fall && in_cycle) st <= XS_MOVING;
        XS_MOVING: if (strb_rise) st <= XS_IDLE;
        default:   st <= XS_IDLE;
      endcase
    end
  end

  assign armed  = (st == XS_ARMED);
  assign moving = (st == XS_MOVING);
  assign commit = moving && strb_rise;
endmodule

// File: rtl/hdm_regs.sv
module hdm_regs
  import hdm_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              loc_wr,
  input  logic              loc_rd,
  input  logic [ADDR_W-1:0] loc_addr,
  input  logic [DATA_W-1:0] loc_wdata,
  output logic [DATA_W-1:0] loc_rdata,
  input  logic [DATA_W-1:0] host_byte,
  input  logic              h2l_commit,
  input  logic              l2h_commit,
  input  logic              w_armed,
  input  logic              r_armed,
  output logic              arm_w,
  output logic              arm_r,
  output logic              h2l_full,
  output logic              l2h_full,
  output logic [DATA_W-1:0] l2h_data
);
  logic [DATA_W-1:0] h2l_data;
  logic              wr_data, wr_ctrl, rd_data;
  logic [DATA_W-1:0] status;

  assign wr_data = loc_wr && (loc_addr == ADDR_W'(RA_DATA));
  assign wr_ctrl = loc_wr && (loc_addr == ADDR_W'(RA_CTRL));
  assign rd_data = loc_rd && (loc_addr == ADDR_W'(RA_DATA));

  assign arm_w = wr_ctrl && loc_wdata[CTL_ARM_W] && !h2l_full;
  assign arm_r = wr_ctrl && loc_wdata[CTL_ARM_R] && l2h_full;

  always_ff @(posedge clk) begin
    if (rst) begin
      h2l_full <= 1'b0;
      h2l_data <= '0;
    end else if (h2l_commit) begin
      h2l_full <= 1'b1;
      h2l_data <= host_byte;
    end else if (rd_data) begin
      h2l_full <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      l2h_full <= 1'b0;
      l2h_data <= '0;
    end else if (l2h_commit) begin
      l2h_full <= 1'b0;
    end else if (wr_data && !l2h_full) begin
      l2h_full <= 1'b1;
      l2h_data <= loc_wdata;
    end
  end

  always_comb begin
    status              = '0;
    status[ST_H2L_FULL] = h2l_full;
    status[ST_L2H_FULL] = l2h_full;
    status[ST_W_ARMED]  = w_armed;
    status[ST_R_ARMED]  = r_armed;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      loc_rdata <= '0;
    end else if (loc_rd) begin
      case (loc_addr)
        ADDR_W'(RA_DATA): loc_rdata <= h2l_data;
        ADDR_W'(RA_STAT): loc_rdata <= status;
        default:          loc_rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/host_dma_mailbox.sv
module host_dma_mailbox
  import hdm_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int ADDR_W      = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              host_ack_n,
  input  logic              host_wr_n,
  input  logic              host_rd_n,
  input  logic              host_port_sel,
  input  logic [DATA_W-1:0] host_data_in,
  output logic [DATA_W-1:0] host_data_out,
  output logic              host_req,
  output logic              host_drv_dis_n,
  output logic              host_cs_n,
  input  logic              loc_wr,
  input  logic              loc_rd,
  input  logic [ADDR_W-1:0] loc_addr,
  input  logic [DATA_W-1:0] loc_wdata,
  output logic [DATA_W-1:0] loc_rdata
);
  localparam int DATA_STAGES = SYNC_STAGES + 1;

  logic [2:0]        ctl_s;
  logic [1:0]        strb_prev;
  logic [DATA_W-1:0] host_byte;
  logic              in_cycle, wr_fall, wr_rise, rd_fall, rd_rise;
  logic              dma_fall_evt;
  logic              arm_w, arm_r;
  logic              w_armed, w_moving, w_commit;
  logic              r_armed, r_moving, r_commit;
  logic              h2l_full, l2h_full;

  hdm_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b111)) u_ctl_sync (
    .clk(clk), .rst(rst),
    .d({host_ack_n, host_wr_n, host_rd_n}),
    .q(ctl_s)
  );

  hdm_sync #(.W(DATA_W), .STAGES(DATA_STAGES), .RST_VAL('0)) u_data_dly (
    .clk(clk), .rst(rst), .d(host_data_in), .q(host_byte)
  );

  always_ff @(posedge clk) begin
    if (rst) strb_prev <= 2'b11;
    else     strb_prev <= ctl_s[1:0];
  end

  assign in_cycle     = !ctl_s[2];
  assign wr_fall      =  strb_prev[1] && !ctl_s[1];
  assign wr_rise      = !strb_prev[1] &&  ctl_s[1];
  assign rd_fall      =  strb_prev[0] && !ctl_s[0];
  assign rd_rise      = !strb_prev[0] &&  ctl_s[0];
  assign dma_fall_evt = in_cycle && (wr_fall || rd_fall);

  hdm_dir u_wdir (
    .clk(clk), .rst(rst), .arm(arm_w), .in_cycle(in_cycle),
    .strb_fall(wr_fall), .strb_rise(wr_rise),
    .armed(w_armed), .moving(w_moving), .commit(w_commit)
  );

  hdm_dir u_rdir (
    .clk(clk), .rst(rst), .arm(arm_r), .in_cycle(in_cycle),
    .strb_fall(rd_fall), .strb_rise(rd_rise),
    .armed(r_armed), .moving(r_moving), .commit(r_commit)
  );

  hdm_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst(rst),
    .loc_wr(loc_wr), .loc_rd(loc_rd), .loc_addr(loc_addr),
    .loc_wdata(loc_wdata), .loc_rdata(loc_rdata),
    .host_byte(host_byte), .h2l_commit(w_commit), .l2h_commit(r_commit),
    .w_armed(w_armed), .r_armed(r_armed),
    .arm_w(arm_w), .arm_r(arm_r),
    .h2l_full(h2l_full), .l2h_full(l2h_full), .l2h_data(host_data_out)
  );

  assign host_req       = w_armed || r_armed;
  assign host_drv_dis_n = !(!host_rd_n && (!host_ack_n || host_port_sel));
  assign host_cs_n      = !(host_port_sel && host_ack_n && (!host_rd_n || !host_wr_n));
endmodule

// File: rtl/hdm_checker.sv
module hdm_checker #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              host_ack_n,
  input logic              host_cs_n,
  input logic              host_req,
  input logic [DATA_W-1:0] host_data_out,
  input logic              dma_fall_evt,
  input logic              w_armed,
  input logic              w_moving,
  input logic              r_armed,
  input logic              r_moving,
  input logic              h2l_full,
  input logic              l2h_full
);
  AST_CS_QUIET_IN_DMA: assert property (@(posedge clk) disable iff (rst)
    !host_ack_n |-> host_cs_n); // R10
  AST_REQ_DROP_ON_STROBE: assert property (@(posedge clk) disable iff (rst)
    $fell(host_req) |-> $past(dma_fall_evt)); // R4 R5
  AST_WREQ_ONLY_EMPTY: assert property (@(posedge clk) disable iff (rst)
    $rose(w_armed) |-> !h2l_full); // R2
  AST_RREQ_ONLY_FULL: assert property (@(posedge clk) disable iff (rst)
    (r_armed || r_moving) |-> l2h_full); // R3
  AST_H2L_SET_ON_COMMIT: assert property (@(posedge clk) disable iff (rst)
    $rose(h2l_full) |-> $past(w_moving)); // R6
  AST_L2H_HELD: assert property (@(posedge clk) disable iff (rst)
    (l2h_full && $past(l2h_full)) |-> $stable(host_data_out)); // R7
endmodule

bind host_dma_mailbox hdm_checker #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .host_ack_n(host_ack_n), .host_cs_n(host_cs_n),
  .host_req(host_req), .host_data_out(host_data_out),
  .dma_fall_evt(dma_fall_evt), .w_armed(w_armed), .w_moving(w_moving),
  .r_armed(r_armed), .r_moving(r_moving),
  .h2l_full(h2l_full), .l2h_full(l2h_full)
);

// File: tb/host_dma_mailbox_tb.sv
module host_dma_mailbox_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       host_ack_n = 1'b1, host_wr_n = 1'b1, host_rd_n = 1'b1;
  logic       host_port_sel = 1'b0;
  logic [7:0] host_data_in = '0;
  logic [7:0] host_data_out;
  logic       host_req, host_drv_dis_n, host_cs_n;
  logic       loc_wr = 1'b0, loc_rd = 1'b0;
  logic [1:0] loc_addr = '0;
  logic [7:0] loc_wdata = '0;
  logic [7:0] loc_rdata;
  int         n_checks = 0, n_fail = 0;
  logic [7:0] rd;

  always #5 clk = ~clk;

  host_dma_mailbox u_dut (
    .clk(clk), .rst(rst), .host_ack_n(host_ack_n), .host_wr_n(host_wr_n),
    .host_rd_n(host_rd_n), .host_port_sel(host_port_sel),
    .host_data_in(host_data_in), .host_data_out(host_data_out),
    .host_req(host_req), .host_drv_dis_n(host_drv_dis_n), .host_cs_n(host_cs_n),
    .loc_wr(loc_wr), .loc_rd(loc_rd), .loc_addr(loc_addr),
    .loc_wdata(loc_wdata), .loc_rdata(loc_rdata)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic loc_write(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    loc_wr = 1'b1; loc_addr = a; loc_wdata = d;
    @(negedge clk);
    loc_wr = 1'b0;
  endtask

  task automatic loc_read(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    loc_rd = 1'b1; loc_addr = a;
    @(posedge clk); #1;
    d = loc_rdata;
    @(negedge clk);
    loc_rd = 1'b0;
  endtask

  task automatic t_reset;
    idle(3);
    check("R1 host_req", host_req, 0);
    check("R1 drv_dis_n", host_drv_dis_n, 1);
    check("R1 cs_n", host_cs_n, 1);
    loc_read(2'd1, rd);
    check("R1 status", rd, 8'h00);
  endtask

  task automatic t_host_write(input logic [7:0] b);
    loc_write(2'd2, 8'h01);
    idle(2);
    check("R2 req raised", host_req, 1);
    loc_read(2'd1, rd);
    check("R2 status armed", rd, 8'h04);
    host_ack_n = 1'b0;
    idle(6);
    check("R4 req held under ack", host_req, 1);
    host_data_in = b; host_wr_n = 1'b0;
    #1;
    check("R9 drv_dis_n high in DMA write", host_drv_dis_n, 1);
    check("R10 cs_n quiet in DMA write", host_cs_n, 1);
    idle(6);
    check("R4 req dropped on strobe", host_req, 0);
    host_wr_n = 1'b1;
    idle(6);
    host_ack_n = 1'b1; host_data_in = 8'h00;
    idle(2);
    loc_read(2'd1, rd);
    check("R6 h2l full", rd, 8'h01);
    loc_write(2'd2, 8'h01);
    idle(2);
    check("R2 arm ignored when full", host_req, 0);
    loc_read(2'd0, rd);
    check("R6 data", rd, b);
    loc_read(2'd1, rd);
    check("R6 full cleared", rd, 8'h00);
  endtask

  task automatic t_stray;
    host_port_sel = 1'b0;
    host_wr_n = 1'b0; host_data_in = 8'hEE; idle(5); host_wr_n = 1'b1; idle(5);
    host_ack_n = 1'b0; idle(3);
    host_wr_n = 1'b0; idle(5); host_wr_n = 1'b1; idle(3);
    host_rd_n = 1'b0; idle(5); host_rd_n = 1'b1; idle(3);
    host_ack_n = 1'b1; idle(3);
    check("R11 req quiet", host_req, 0);
    loc_read(2'd1, rd);
    check("R11 flags unchanged", rd, 8'h00);
  endtask

  task automatic t_local_to_host;
    loc_write(2'd2, 8'h02);
    idle(2);
    check("R3 arm ignored when empty", host_req, 0);
    loc_write(2'd0, 8'h3C);
    idle(1);
    loc_read(2'd1, rd);
    check("R7 l2h full", rd, 8'h02);
    check("R7 byte out", host_data_out, 8'h3C);
    loc_write(2'd0, 8'h99);
    idle(1);
    check("R7 overwrite ignored", host_data_out, 8'h3C);
    loc_write(2'd2, 8'h02);
    idle(2);
    check("R3 req raised", host_req, 1);
    host_ack_n = 1'b0;
    idle(6);
    check("R5 req held under ack", host_req, 1);
    host_rd_n = 1'b0;
    #1;
    check("R9 drv_dis_n low in DMA read", host_drv_dis_n, 0);
    check("R10 cs_n quiet in DMA read", host_cs_n, 1);
    check("R8 data on host bus", host_data_out, 8'h3C);
    idle(6);
    check("R5 req dropped on strobe", host_req, 0);
    host_rd_n = 1'b1;
    idle(6);
    host_ack_n = 1'b1;
    idle(2);
    check("R9 drv_dis_n released", host_drv_dis_n, 1);
    loc_read(2'd1, rd);
    check("R8 l2h cleared", rd, 8'h00);
  endtask

  task automatic t_ordinary;
    host_port_sel = 1'b1;
    host_rd_n = 1'b0; #1;
    check("R9 drv_dis_n on ordinary read", host_drv_dis_n, 0);
    check("R10 cs_n on ordinary read", host_cs_n, 0);
    host_rd_n = 1'b1; #1;
    check("R10 cs_n idle", host_cs_n, 1);
    host_wr_n = 1'b0; #1;
    check("R10 cs_n on ordinary write", host_cs_n, 0);
    check("R9 drv_dis_n on ordinary write", host_drv_dis_n, 1);
    host_wr_n = 1'b1; host_port_sel = 1'b0;
    idle(5);
    check("R11 req quiet after ordinary", host_req, 0);
    loc_read(2'd1, rd);
    check("R11 flags after ordinary", rd, 8'h00);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_host_write(8'hA5);
    t_stray();
    t_local_to_host();
    t_ordinary();
    t_host_write(8'h5A);
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end
endmodule